// File: doc/BRIEF.md
# Machine-Cycle Timing and Bus Strobe Generator

This block splits the input clock into fixed-length machine cycles for an 8-bit processor core and derives the external bus timing from the position within the cycle. A phase counter runs through eight clock phases per cycle. The first cycle after a reset runs nine phases, and the extra phase serves as the initialization cycle. From the phase, the block makes two timing pulses, an early one and a late one. It switches the 8-bit multiplexed address port from the high address byte to the low address byte once the early pulse ends. It also makes the read level, the write pulse, the I/O select lines and the strobes that mark when the flag inputs and the request inputs should be sampled.

The core's sequencer supplies the current machine state, the cycle kind and the 16-bit address. This block leaves the sequencing of states to the core and controls only timing. Two active-low control inputs choose one of four operating modes: load, reset, pause and run. Pause freezes the phase counter in place, and run or load lets it advance. Reset mode holds the counter at phase 0, blocks the pulses and arms the longer initialization cycle. Load mode runs like run mode, except that the early pulse is blocked while the core is idling.

Top module: `mcycle_bus_timer`

## Requirements
- R1: In run mode and in load mode the phase advances one step per clock, and a normal cycle lasts 8 clocks. `cycle_end_o` is high for exactly one clock, on the last phase of each cycle (phase 7 in a normal cycle).
- R2: The first cycle after reset mode is left lasts 9 clocks, running phases 0 through 8. `init_cycle_o` is high throughout that cycle. The first `cycle_end_o` comes on the 8th rising edge after the mode changes to run, and the next one comes 8 edges after that.
- R3: `tpa_o` is high only in phase 1 and `tpb_o` is high only in phase 6, so each pulses once per cycle and never at the same time as the other.
- R4: `ma_o` carries `addr_i[15:8]` in phases 0 and 1 and carries `addr_i[7:0]` in every later phase of the cycle.
- R5: `mrd_n_o` is low whenever the cycle kind is read (code 1). `mwr_n_o` is low only in phases 5 and 6 of a write cycle (code 2). Codes 0 and 3 drive neither strobe.
- R6: `n_o` equals `io_code_i` when the state is execute (code 1) and `io_instr_i` is high. Otherwise `n_o` is zero. In reset mode `n_o` is also zero.
- R7: The mode is {`clear_n_i`,`wait_n_i`}: 00 is load, 01 is reset, 10 is pause, 11 is run. Reset mode, or `rst_n` low, holds phase 0 and arms the initialization cycle. It also keeps `tpa_o`, `tpb_o`, the sample strobes and `cycle_end_o` low, and keeps both `mrd_n_o` and `mwr_n_o` high.
- R8: Pause mode holds the phase. No `cycle_end_o` or sample strobe is raised during pause, and the phase-driven outputs stay unchanged. Run mode resumes the cycle from the held phase.
- R9: In load mode with `idle_i` high, `tpa_o` stays low. `tpb_o` and all other outputs behave as in run mode.
- R10: `flag_smp_o` is high on phase 0 of an execute-state cycle (state code 1) while the counter advances. `req_smp_o` is high on phase 7 while the counter advances, which places it after the late pulse and before the next early pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Synchronous active-low reset, acts as reset mode |
| wait_n_i | input | 1 | Mode control, low half of the mode code |
| clear_n_i | input | 1 | Mode control, high half of the mode code |
| mstate_i | input | 2 | Machine state: 0 fetch, 1 execute, 2 DMA, 3 interrupt |
| cyc_kind_i | input | 2 | Cycle kind: 0 none, 1 read, 2 write, 3 none |
| io_instr_i | input | 1 | The current instruction is an I/O transfer |
| io_code_i | input | 3 | I/O select code from the instruction |
| idle_i | input | 1 | The core is executing its idle instruction |
| addr_i | input | 16 | Memory address for the current cycle |
| tpa_o | output | 1 | Early timing pulse |
| tpb_o | output | 1 | Late timing pulse |
| ma_o | output | 8 | Multiplexed address byte |
| mrd_n_o | output | 1 | Read level, active low |
| mwr_n_o | output | 1 | Write pulse, active low |
| n_o | output | 3 | I/O select lines |
| cycle_end_o | output | 1 | Last clock of the machine cycle |
| init_cycle_o | output | 1 | The initialization cycle is in progress |
| flag_smp_o | output | 1 | Flag-input sampling strobe |
| req_smp_o | output | 1 | Request-input sampling strobe |

## Verification
On every cycle the assertions check the following properties:
- The two pulses never overlap.
- The write strobe never coincides with the read level.
- The high address byte is present whenever the early pulse is high.
- The I/O lines are quiet outside execute cycles.
- The phase stays within its bound, holds during pause and returns to zero in reset mode.
- A cycle-end pulse always leads to phase 0 with the initialization flag cleared.

Only the bench's scenarios can show the following:
- The nine-clock length of the first cycle.
- The exact phase at which each strobe appears under every mode and input combination.
- Resuming from pause at each possible phase.
- Restarting after reset mode is entered in the middle of a cycle.

// File: rtl/bct_pkg.sv
// Package: shared encodings for the machine-cycle timing generator.
// Assumes the mode code is formed as {clear_n, wait_n}.
package bct_pkg;
    typedef enum logic [1:0] {
        MODE_LOAD  = 2'b00,
        MODE_RESET = 2'b01,
        MODE_PAUSE = 2'b10,
        MODE_RUN   = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        ST_FETCH = 2'd0,
        ST_EXEC  = 2'd1,
        ST_DMA   = 2'd2,
        ST_INTR  = 2'd3
    } mstate_e;

    typedef enum logic [1:0] {
        CK_NONE  = 2'd0,
        CK_READ  = 2'd1,
        CK_WRITE = 2'd2,
        CK_SPARE = 2'd3
    } ckind_e;
endpackage

// File: rtl/bct_mode_decode.sv
// Module: bct_mode_decode
// Turns the two control pins into an operating mode. A low block reset
// is treated as reset mode, so the rest of the block sees a single source.
// Assumes the control pins are already synchronous to clk.
module bct_mode_decode
    import bct_pkg::*;
(
    input  logic  rst_n,
    input  logic  wait_n_i,
    input  logic  clear_n_i,
    output mode_e mode_o
);
    // Purpose: select the mode, with block reset overriding the pins.
    always_comb begin
        if (!rst_n) mode_o = MODE_RESET;
        else        mode_o = mode_e'({clear_n_i, wait_n_i});
    end
endmodule

// File: rtl/bct_phase_ctr.sv
// Module: bct_phase_ctr
// Counts clock phases within a machine cycle. A normal cycle spans
// CYCLE_LEN phases. The first cycle after reset mode adds INIT_EXTRA phases.
// The count advances in run and load modes, holds in pause and is
// cleared in reset mode.
module bct_phase_ctr
    import bct_pkg::*;
#(
    parameter int CYCLE_LEN  = 8,
    parameter int INIT_EXTRA = 1,
    parameter int PH_W       = $clog2(CYCLE_LEN + INIT_EXTRA)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  mode_e           mode_i,
    output logic [PH_W-1:0] phase_o,
    output logic            init_o,
    output logic            adv_o,
    output logic            cycle_end_o
);
    localparam logic [PH_W-1:0] LAST_RUN  = PH_W'(CYCLE_LEN - 1);
    localparam logic [PH_W-1:0] LAST_INIT = PH_W'(CYCLE_LEN - 1 + INIT_EXTRA);

    logic [PH_W-1:0] phase_q;
    logic            init_q;
    logic            at_last;

    // Purpose: find the final phase for the kind of cycle in progress.
    always_comb begin
        at_last = init_q ? (phase_q == LAST_INIT) : (phase_q == LAST_RUN);
        adv_o   = (mode_i == MODE_RUN) || (mode_i == MODE_LOAD);
    end

    // Purpose: advance, wrap, hold or clear the phase counter.
    always_ff @(posedge clk) begin
        if (mode_i == MODE_RESET) begin
            phase_q <= '0;
            init_q  <= 1'b1;
        end else if (adv_o) begin
            if (at_last) begin
                phase_q <= '0;
                init_q  <= 1'b0;
            end else begin
                phase_q <= phase_q + 1'b1;
            end
        end
    end

    assign phase_o     = phase_q;
    assign init_o      = init_q;
    assign cycle_end_o = adv_o && at_last;

    AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q <= LAST_INIT); // R1
    AST_WRAP_CLEARS_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_end_o |=> (phase_q == '0) && !init_q); // R2
    AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_PAUSE) |=> (phase_q == $past(phase_q))); // R8
    AST_RESET_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_RESET) |=> (phase_q == '0) && init_q); // R7
endmodule

// File: rtl/bct_bus_drive.sv
// Module: bct_bus_drive
// Derives the timing pulses, the address byte select, the read and write
// strobes, the I/O lines and the sample strobes from the current phase.
// Assumes the phase comes from bct_phase_ctr and the sequencer inputs
// stay valid for the whole cycle.
module bct_bus_drive
    import bct_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int NW        = 3,
    parameter int PH_W      = 4,
    parameter int TPA_PH    = 1,
    parameter int TPB_PH    = 6,
    parameter int MWR_FIRST = 5,
    parameter int MWR_LAST  = 6,
    parameter int FLAG_PH   = 0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  mode_e               mode_i,
    input  logic [PH_W-1:0]     phase_i,
    input  logic                adv_i,
    input  mstate_e             state_i,
    input  ckind_e              kind_i,
    input  logic                io_instr_i,
    input  logic [NW-1:0]       io_code_i,
    input  logic                idle_i,
    input  logic [ADDR_W-1:0]   addr_i,
    output logic                tpa_o,
    output logic                tpb_o,
    output logic [ADDR_W/2-1:0] ma_o,
    output logic                mrd_n_o,
    output logic                mwr_n_o,
    output logic [NW-1:0]       n_o,
    output logic                flag_smp_o,
    output logic                req_smp_o
);
    localparam int              MA_W  = ADDR_W / 2;
    localparam logic [PH_W-1:0] P_TPA = PH_W'(TPA_PH);
    localparam logic [PH_W-1:0] P_TPB = PH_W'(TPB_PH);
    localparam logic [PH_W-1:0] P_WR0 = PH_W'(MWR_FIRST);
    localparam logic [PH_W-1:0] P_WR1 = PH_W'(MWR_LAST);
    localparam logic [PH_W-1:0] P_FLG = PH_W'(FLAG_PH);
    localparam logic [PH_W-1:0] P_REQ = PH_W'(TPB_PH + 1);

    logic active;
    logic hi_sel;
    logic io_live;

    // Purpose: qualifiers shared by all strobes.
    always_comb begin
        active  = (mode_i != MODE_RESET);
        hi_sel  = (phase_i <= P_TPA);
        io_live = active && (state_i == ST_EXEC) && io_instr_i;
    end

    // Purpose: the two timing pulses, with the early one blocked during load-mode idle.
    always_comb begin
        tpa_o = active && (phase_i == P_TPA) && !((mode_i == MODE_LOAD) && idle_i);
        tpb_o = active && (phase_i == P_TPB);
    end

    // Purpose: put the high byte out first, then the low byte after the early pulse.
    always_comb begin
        ma_o = hi_sel ? addr_i[ADDR_W-1:MA_W] : addr_i[MA_W-1:0];
    end

    // Purpose: read level for the whole cycle and a write pulse once the address is stable.
    always_comb begin
        mrd_n_o = !(active && (kind_i == CK_READ));
        mwr_n_o = !(active && (kind_i == CK_WRITE) &&
                    (phase_i >= P_WR0) && (phase_i <= P_WR1));
    end

    // Purpose: gate each I/O select line by the live I/O condition.
    for (genvar b = 0; b < NW; b++) begin : g_nline
        assign n_o[b] = io_live && io_code_i[b];
    end

    // Purpose: sample strobes for the flag and request inputs.
    always_comb begin
        flag_smp_o = adv_i && (state_i == ST_EXEC) && (phase_i == P_FLG);
        req_smp_o  = adv_i && (phase_i == P_REQ);
    end

    AST_TP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(tpa_o && tpb_o)); // R3
    AST_HI_BYTE_AT_TPA: assert property (@(posedge clk) disable iff (!rst_n)
        tpa_o |-> (ma_o == addr_i[ADDR_W-1:MA_W])); // R4
    AST_WR_RD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !mwr_n_o |-> mrd_n_o); // R5
    AST_N_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i != ST_EXEC) |-> (n_o == '0)); // R6
endmodule

// File: rtl/mcycle_bus_timer.sv
// Module: mcycle_bus_timer (top)
// Machine-cycle timing and bus strobe generator. It decodes the operating
// mode, counts phases and drives the bus timing outputs from the phase.
// Assumes every input is synchronous to clk. The pause takes effect at the
// next rising edge in this single-edge design.
module mcycle_bus_timer
    import bct_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int NW         = 3,
    parameter int CYCLE_LEN  = 8,
    parameter int INIT_EXTRA = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wait_n_i,
    input  logic                clear_n_i,
    input  logic [1:0]          mstate_i,
    input  logic [1:0]          cyc_kind_i,
    input  logic                io_instr_i,
    input  logic [NW-1:0]       io_code_i,
    input  logic                idle_i,
    input  logic [ADDR_W-1:0]   addr_i,
    output logic                tpa_o,
    output logic                tpb_o,
    output logic [ADDR_W/2-1:0] ma_o,
    output logic                mrd_n_o,
    output logic                mwr_n_o,
    output logic [NW-1:0]       n_o,
    output logic                cycle_end_o,
    output logic                init_cycle_o,
    output logic                flag_smp_o,
    output logic                req_smp_o
);
    localparam int PH_W = $clog2(CYCLE_LEN + INIT_EXTRA);

    mode_e           mode;
    logic [PH_W-1:0] phase;
    logic            adv;

    bct_mode_decode u_mode (
        .rst_n     (rst_n),
        .wait_n_i  (wait_n_i),
        .clear_n_i (clear_n_i),
        .mode_o    (mode)
    );

    bct_phase_ctr #(
        .CYCLE_LEN  (CYCLE_LEN),
        .INIT_EXTRA (INIT_EXTRA),
        .PH_W       (PH_W)
    ) u_phase (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (mode),
        .phase_o     (phase),
        .init_o      (init_cycle_o),
        .adv_o       (adv),
        .cycle_end_o (cycle_end_o)
    );

    bct_bus_drive #(
        .ADDR_W    (ADDR_W),
        .NW        (NW),
        .PH_W      (PH_W),
        .TPA_PH    (1),
        .TPB_PH    (6),
        .MWR_FIRST (5),
        .MWR_LAST  (6),
        .FLAG_PH   (0)
    ) u_bus (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode),
        .phase_i    (phase),
        .adv_i      (adv),
        .state_i    (mstate_e'(mstate_i)),
        .kind_i     (ckind_e'(cyc_kind_i)),
        .io_instr_i (io_instr_i),
        .io_code_i  (io_code_i),
        .idle_i     (idle_i),
        .addr_i     (addr_i),
        .tpa_o      (tpa_o),
        .tpb_o      (tpb_o),
        .ma_o       (ma_o),
        .mrd_n_o    (mrd_n_o),
        .mwr_n_o    (mwr_n_o),
        .n_o        (n_o),
        .flag_smp_o (flag_smp_o),
        .req_smp_o  (req_smp_o)
    );
endmodule

// File: tb/mcycle_bus_timer_tb_top.sv
`timescale 1ns/1ps
module mcycle_bus_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wait_n = 1'b1;
    logic        clear_n = 1'b0;
    logic [1:0]  mstate = 2'd0;
    logic [1:0]  kind = 2'd0;
    logic        io_instr = 1'b0;
    logic [2:0]  io_code = 3'd0;
    logic        idle = 1'b0;
    logic [15:0] addr = 16'h0000;

    logic        tpa, tpb, mrd_n, mwr_n, cend, initc, fsmp, rsmp;
    logic [7:0]  ma;
    logic [2:0]  n;

    int checks = 0;
    int failures = 0;
    int m_ph = 0;
    bit m_init = 1'b1;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mcycle_bus_timer dut_i (
        .clk(clk), .rst_n(rst_n), .wait_n_i(wait_n), .clear_n_i(clear_n),
        .mstate_i(mstate), .cyc_kind_i(kind), .io_instr_i(io_instr),
        .io_code_i(io_code), .idle_i(idle), .addr_i(addr),
        .tpa_o(tpa), .tpb_o(tpb), .ma_o(ma), .mrd_n_o(mrd_n), .mwr_n_o(mwr_n),
        .n_o(n), .cycle_end_o(cend), .init_cycle_o(initc),
        .flag_smp_o(fsmp), .req_smp_o(rsmp)
    );

    task automatic check(input string rq, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", rq, what, act, exp, $time);
        end
    endtask

    function automatic int mode_now();
        return rst_n ? int'({clear_n, wait_n}) : 1;
    endfunction

    // One clock: update the reference phase at the rising edge, then compare at the falling edge.
    task automatic tick();
        int md;
        bit act, adv, wr;
        int last;
        @(posedge clk);
        md = mode_now();
        if (md == 1) begin
            m_ph = 0; m_init = 1'b1;
        end else if (md == 0 || md == 3) begin
            last = m_init ? 8 : 7;
            if (m_ph == last) begin m_ph = 0; m_init = 1'b0; end
            else m_ph++;
        end
        @(negedge clk);
        md   = mode_now();
        act  = (md != 1);
        adv  = (md == 0 || md == 3);
        last = m_init ? 8 : 7;
        wr   = act && kind == 2 && m_ph >= 5 && m_ph <= 6;
        check((md == 0 && idle) ? "R9" : (act ? "R3" : "R7"), "tpa",
              tpa, act && m_ph == 1 && !(md == 0 && idle));
        check(act ? "R3" : "R7", "tpb", tpb, act && m_ph == 6);
        check("R4", "ma", ma, (m_ph <= 1) ? addr[15:8] : addr[7:0]);
        check(act ? "R5" : "R7", "mrd_n", mrd_n, !(act && kind == 1));
        check(act ? "R5" : "R7", "mwr_n", mwr_n, !wr);
        check("R6", "n", n, (act && mstate == 1 && io_instr) ? io_code : 0);
        check(md == 2 ? "R8" : "R1", "cycle_end", cend, adv && m_ph == last);
        check("R2", "init", initc, m_init);
        check("R10", "flag_smp", fsmp, adv && mstate == 1 && m_ph == 0);
        check("R10", "req_smp", rsmp, adv && m_ph == 7);
    endtask

    task automatic set_mode(input bit c, input bit w);
        clear_n = c; wait_n = w;
    endtask

    initial begin
        int cnt;
        int first_end;
        int second_end;
        // Reset state with the block reset and then reset mode.
        for (int i = 0; i < 3; i++) tick();
        rst_n = 1'b1;
        set_mode(1'b0, 1'b1);
        for (int i = 0; i < 2; i++) tick();
        // R2: count edges from release to the first and second cycle_end.
        set_mode(1'b1, 1'b1);
        first_end = 0; second_end = 0;
        for (int i = 1; i <= 20; i++) begin
            tick();
            if (cend && first_end == 0) first_end = i;
            else if (cend && second_end == 0) second_end = i;
        end
        check("R2", "first cycle_end edge", first_end, 8);
        check("R1", "cycle spacing", second_end - first_end, 8);
        // Sweep of run and load modes over every combination of kind, state, io and idle.
        for (int md = 0; md < 2; md++) begin
            if (md == 0) set_mode(1'b1, 1'b1); else set_mode(1'b0, 1'b0);
            for (int idx = 0; idx < 64; idx++) begin
                kind     = idx[1:0];
                mstate   = idx[3:2];
                io_instr = idx[4];
                idle     = idx[5];
                io_code  = 3'(idx * 5 + 3);
                addr     = 16'((idx * 16'h0937 + 16'h5a0c) ^ (md * 16'hf00f));
                for (int k = 0; k < 8; k++) tick();
            end
        end
        // R8: pause at each phase and check the held outputs, then resume.
        set_mode(1'b1, 1'b1);
        kind = 2'd2; mstate = 2'd1; io_instr = 1'b1; idle = 1'b0;
        for (int p = 0; p < 8; p++) begin
            logic [7:0] ma_s;
            logic tpa_s, tpb_s, mwr_s;
            cnt = 0;
            while (!tpa && cnt < 20) begin tick(); cnt++; end
            for (int k = 0; k < p; k++) tick();
            ma_s = ma; tpa_s = tpa; tpb_s = tpb; mwr_s = mwr_n;
            set_mode(1'b1, 1'b0);
            for (int k = 0; k < 4; k++) tick();
            check("R8", "held ma", ma, ma_s);
            check("R8", "held tpa", tpa, tpa_s);
            check("R8", "held tpb", tpb, tpb_s);
            check("R8", "held mwr_n", mwr_n, mwr_s);
            check("R8", "no cycle_end in pause", cend, 0);
            set_mode(1'b1, 1'b1);
            for (int k = 0; k < 3; k++) tick();
        end
        // R7: reset mode entered at several points mid-cycle, then restart.
        for (int p = 0; p < 9; p++) begin
            for (int k = 0; k < p + 2; k++) tick();
            set_mode(1'b0, 1'b1);
            for (int k = 0; k < 2; k++) tick();
            check("R7", "reset tpa", tpa, 0);
            check("R7", "reset mrd_n", mrd_n, 1);
            set_mode(1'b1, 1'b1);
            for (int k = 0; k < 20; k++) tick();
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog run did not complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule